// File: doc/BRIEF.md
# SRAM Configuration Register Block

A compact 32-bit register slave that sits on a simple memory-mapped request/response port. It holds three pieces of state: a system SRAM configuration word, a guarded chip-identification register, and a general-purpose scratch word that boot software may use as a soft entry pointer. The block decodes a 1 KiB window and accepts only naturally aligned full-word accesses.

The identification register hides its content until software sets its enable flag (bit 15). Once the flag is set, reads return the flag together with a fixed 16-bit chip code in the upper half. Any access to an unmapped offset, or any access that is misaligned or has partial byte enables, is rejected. A rejected access returns zero, changes no state, and raises a one-cycle error strobe alongside its response. Every response, read data included, arrives one clock after the request is accepted.

Top module: `sramcfg_regs`

## Requirements
- R1: After reset the configuration word reads 0x0000_1300 (parameter CFG_RESET), the scratch word reads 0, and the identification register reads 0.
- R2: The configuration word at offset 0x04 holds all 32 written bits and reads them back unchanged.
- R3: The scratch word at offset 0xBC holds all 32 written bits and reads them back unchanged.
- R4: A write to the identification register at offset 0x24 stores only bit 15. All other written bits are dropped.
- R5: While the stored bit 15 is clear, a read of offset 0x24 returns 0. While it is set, the read returns {CHIP_CODE, 16'h8000}, where the default CHIP_CODE is 0x1701.
- R6: A read of an unmapped offset inside the window returns 0 and asserts err_o. A write to an unmapped offset changes no register and asserts err_o.
- R7: An access with addr[1:0] not equal to 0, or with be_i not equal to 4'hF, is rejected. It asserts err_o, returns 0 and changes no register.
- R8: The block accepts every request (req_ready_o is always 1). rsp_valid_o and err_o rise for exactly one cycle, on the clock after acceptance, and read data is valid in that same cycle.
- R9: Only address bits [9:0] are decoded, so offsets repeat every 1 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_be_i | input | 4 | Byte enables |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Read data (0 for writes and errors) |
| rsp_err_o | output | 1 | Error pulse aligned with the response |

## Verification
Read/write traffic uses several data patterns: all ones, alternating bits, and walking values. These show that each full-width register keeps every bit and that the identification register masks all bits except bit 15. The identification register is read with the flag clear, then set, then cleared again, which separates the gated zero from the code readout. Misaligned addresses, partial byte enables, unmapped offsets and aliased addresses above 1 KiB are each followed by read-backs of all registers. These read-backs show that the rejected cycles left no trace and that the error pulse is tied to the right response.

// File: rtl/sramcfg_pkg.sv
package sramcfg_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 32;
    localparam int unsigned WIN_BITS = 10;

    localparam logic [WIN_BITS-1:0] OFF_CFG   = 10'h004;
    localparam logic [WIN_BITS-1:0] OFF_ID    = 10'h024;
    localparam logic [WIN_BITS-1:0] OFF_ENTRY = 10'h0BC;
    localparam int unsigned ID_EN_BIT = 15;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CFG   = 2'd1,
        SEL_ID    = 2'd2,
        SEL_ENTRY = 2'd3
    } sel_e;
endpackage

// File: rtl/sramcfg_decode.sv
module sramcfg_decode
    import sramcfg_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    input  logic [3:0]    be_i,
    output sel_e          sel_o,
    output logic          bad_o
);
    logic [WIN_BITS-1:0] off;
    logic                shape_ok;

    always_comb begin
        off      = addr_i[WIN_BITS-1:0];
        shape_ok = (addr_i[1:0] == 2'b00) && (be_i == 4'hF);
        unique case (off)
            OFF_CFG:   sel_o = SEL_CFG;
            OFF_ID:    sel_o = SEL_ID;
            OFF_ENTRY: sel_o = SEL_ENTRY;
            default:   sel_o = SEL_NONE;
        endcase
        if (!shape_ok) sel_o = SEL_NONE;
        bad_o = (sel_o == SEL_NONE);
    end
endmodule

// File: rtl/sramcfg_regs.sv
module sramcfg_regs
    import sramcfg_pkg::*;
#(
    parameter logic [15:0]   CHIP_CODE = 16'h1701,
    parameter logic [DW-1:0] CFG_RESET = 32'h0000_1300
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [3:0]    req_be_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o,
    output logic          rsp_err_o
);
    typedef struct packed {
        logic [DW-1:0] cfg;
        logic          id_en;
        logic [DW-1:0] entry;
        logic          rvalid;
        logic [DW-1:0] rdata;
        logic          err;
    } state_t;

    state_t s_d, s_q;
    sel_e   sel;
    logic   bad;

    sramcfg_decode u_dec (
        .addr_i (req_addr_i),
        .be_i   (req_be_i),
        .sel_o  (sel),
        .bad_o  (bad)
    );

    assign req_ready_o = 1'b1;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = req_valid_i;
        s_d.err    = req_valid_i && bad;
        s_d.rdata  = '0;
        if (req_valid_i) begin
            if (req_write_i) begin
                unique case (sel)
                    SEL_CFG:   s_d.cfg   = req_wdata_i;
                    SEL_ID:    s_d.id_en = req_wdata_i[ID_EN_BIT];
                    SEL_ENTRY: s_d.entry = req_wdata_i;
                    default:   ;
                endcase
            end else begin
                unique case (sel)
                    SEL_CFG:   s_d.rdata = s_q.cfg;
                    SEL_ID:    s_d.rdata = s_q.id_en ? {CHIP_CODE, 16'h8000} : '0;
                    SEL_ENTRY: s_d.rdata = s_q.entry;
                    default:   s_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.cfg   <= CFG_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o = s_q.rvalid;
    assign rsp_rdata_o = s_q.rdata;
    assign rsp_err_o   = s_q.err;

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);
    // R8
    err_inside_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_err_o |-> rsp_valid_o);
    // R6
    err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_err_o |-> (rsp_rdata_o == '0));
    // R7
    bad_shape_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (req_be_i != 4'hF)) |=> $stable(s_q.cfg) && $stable(s_q.entry) && $stable(s_q.id_en));
    // R5
    id_read_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && req_addr_i[9:0] == OFF_ID && req_be_i == 4'hF)
        |=> (rsp_rdata_o == '0 || rsp_rdata_o == {CHIP_CODE, 16'h8000}));
endmodule

// File: tb/sramcfg_regs_bench.sv
module sramcfg_regs_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        valid = 0, wr = 0;
    logic [31:0] addr = 0, wdata = 0;
    logic [3:0]  be = 4'hF;
    logic        ready, rvalid, err;
    logic [31:0] rdata;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sramcfg_regs u_sramcfg_regs (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
        .req_write_i(wr), .req_addr_i(addr), .req_be_i(be), .req_wdata_i(wdata),
        .rsp_valid_o(rvalid), .rsp_rdata_o(rdata), .rsp_err_o(err)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one access; returns response sampled mid-cycle after the edge
    task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, output logic [31:0] rd, output logic e,
                        output logic v);
        @(negedge clk);
        valid = 1; wr = w; addr = a; wdata = d; be = b;
        @(negedge clk);
        valid = 0;
        rd = rdata; e = err; v = rvalid;
    endtask

    task automatic rd_chk(string rq, logic [31:0] a, logic [31:0] exp);
        logic [31:0] d; logic e, v;
        xfer(0, a, 0, 4'hF, d, e, v);
        chk(rq, d, exp);
        chk({rq, " err"}, {31'b0, e}, 0);
        chk({rq, " valid"}, {31'b0, v}, 1);
    endtask

    task automatic wr_do(logic [31:0] a, logic [31:0] d);
        logic [31:0] r; logic e, v;
        xfer(1, a, d, 4'hF, r, e, v);
    endtask

    task automatic t_reset;   // R1
        rd_chk("R1 cfg", 32'h04, 32'h0000_1300);
        rd_chk("R1 entry", 32'hBC, 0);
        rd_chk("R1 id", 32'h24, 0);
        chk("R8 ready", {31'b0, ready}, 1);
    endtask

    task automatic t_rw;      // R2 R3
        logic [31:0] pats[4] = '{32'hFFFF_FFFF, 32'hAAAA_5555, 32'h0000_0001, 32'h8000_0000};
        foreach (pats[i]) begin
            wr_do(32'h04, pats[i]);
            wr_do(32'hBC, ~pats[i]);
            rd_chk("R2 cfg", 32'h04, pats[i]);
            rd_chk("R3 entry", 32'hBC, ~pats[i]);
        end
    endtask

    task automatic t_id;      // R4 R5
        wr_do(32'h24, 32'hFFFF_7FFF);
        rd_chk("R4 masked", 32'h24, 0);
        wr_do(32'h24, 32'h0000_8000);
        rd_chk("R5 enabled", 32'h24, 32'h1701_8000);
        wr_do(32'h24, 32'h0000_0000);
        rd_chk("R5 cleared", 32'h24, 0);
    endtask

    task automatic t_unmapped; // R6 R8
        logic [31:0] d; logic e, v;
        wr_do(32'h04, 32'h1234_5678);
        xfer(0, 32'h08, 0, 4'hF, d, e, v);
        chk("R6 rd data", d, 0); chk("R6 rd err", {31'b0, e}, 1);
        @(negedge clk);
        chk("R8 err one cycle", {31'b0, err}, 0);
        chk("R8 valid one cycle", {31'b0, rvalid}, 0);
        xfer(1, 32'h3FC, 32'hDEAD_BEEF, 4'hF, d, e, v);
        chk("R6 wr err", {31'b0, e}, 1);
        rd_chk("R6 cfg kept", 32'h04, 32'h1234_5678);
    endtask

    task automatic t_shape;   // R7
        logic [31:0] d; logic e, v;
        xfer(1, 32'h06, 32'hFFFF_FFFF, 4'hF, d, e, v);
        chk("R7 misaligned err", {31'b0, e}, 1);
        xfer(1, 32'hBC, 32'hFFFF_FFFF, 4'h3, d, e, v);
        chk("R7 partial be err", {31'b0, e}, 1);
        xfer(1, 32'h24, 32'hFFFF_FFFF, 4'h7, d, e, v);
        xfer(0, 32'h05, 0, 4'hF, d, e, v);
        chk("R7 misaligned read data", d, 0);
        chk("R7 misaligned read err", {31'b0, e}, 1);
        rd_chk("R7 cfg kept", 32'h04, 32'h1234_5678);
        rd_chk("R7 entry kept", 32'hBC, 32'h7FFF_FFFF);
        rd_chk("R7 id kept", 32'h24, 0);
    endtask

    task automatic t_alias;   // R9
        wr_do(32'h0000_0404, 32'hCAFE_F00D);
        rd_chk("R9 alias cfg", 32'h04, 32'hCAFE_F00D);
        rd_chk("R9 alias read", 32'h8000_08BC, 32'h7FFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rw();
        t_id();
        t_unmapped();
        t_shape();
        t_alias();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule